// File: doc/BRIEF.md
# Three-Level Tiled-Resource Address Translator

This block sits in front of a second-stage page translator and remaps 48-bit graphics virtual addresses that land in a reserved one-sixteenth slice of the address space. A four-bit mask/data compare against the top address nibble selects the slice. Each address inside it walks a three-level table held in memory. The walk reads a 64-bit root-level entry, then a 64-bit mid-level entry, then a 32-bit leaf entry. The leaf entry names a 64KB tile in the intermediate address space, and the low 16 address bits are kept as the offset within that tile.

Two programmable sentinel values mark special entries. If any fetched entry equals the invalid pattern, the walk stops and a fault is reported. If a leaf entry equals the null pattern, the response flags a hole in a sparse resource. When the block is disabled, or the address lies outside the slice, the address is returned unchanged one cycle after it is accepted, and no memory read is made. The block handles one request at a time through a valid/ready request port, a response port with back-pressure, and a table read port that has a valid/ready request and a data-valid return.

Top module: `tiled_xlate`

## Requirements
- R1: While reset is asserted and on release, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: When `cfg_enable` is 0, an accepted request is answered in the next cycle with `rsp_addr` equal to `req_addr`, with `rsp_null` and `rsp_fault` both 0, and with no table read.
- R3: With `cfg_enable` at 1, a request hits the slice exactly when `((req_addr[47:44] ^ cfg_seg_data) & cfg_seg_mask) == 0`. A miss is answered like R2.
- R4: A hit issues its table reads in this order. Root: `{cfg_root_tile,16'h0} + req_addr[43:35]*8`. Mid: `{root_entry[47:12],12'h0} + req_addr[34:26]*8`. Leaf: `{mid_entry[47:12],12'h0} + req_addr[25:16]*4`. No further reads are made once the walk ends.
- R5: A completed walk returns `rsp_addr = {leaf_entry, req_addr[15:0]}`, with both flags 0.
- R6: If a root or mid entry equals `cfg_inv_pat` zero-extended to 64 bits, or a leaf entry equals `cfg_inv_pat`, the walk stops at once. The response then has `rsp_fault`=1, `rsp_null`=0 and `rsp_addr`=0. The invalid check takes priority over the null check.
- R7: A leaf entry equal to `cfg_null_pat` (and not invalid) gives `rsp_null`=1, `rsp_fault`=0 and `rsp_addr`=0.
- R8: `req_ready` is low from the cycle after acceptance until the response handshake. A response held under `rsp_valid` with `rsp_ready` low keeps its address and flags.
- R9: A table read request keeps `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`. The leaf entry is taken from `mem_rsp_data[31:0]`. The bits of upper-level entries outside 47:12 do not affect the next base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_seg_mask | input | 4 | Mask applied to address bits 47:44 |
| cfg_seg_data | input | 4 | Compare value for address bits 47:44 |
| cfg_root_tile | input | 32 | Root table pointer, address bits 47:16 |
| cfg_null_pat | input | 32 | Leaf value that marks a null tile |
| cfg_inv_pat | input | 32 | Entry value that marks an invalid tile |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready for a new request |
| req_addr | input | 48 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_addr | output | 48 | Translated or passed-through address |
| rsp_null | output | 1 | Null tile hit |
| rsp_fault | output | 1 | Invalid tile fault |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | 48 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry data (a leaf entry is in bits 31:0) |

## Verification
The assertions assume the following about the inputs. The configuration does not change while a request is in flight. `mem_rsp_valid` pulses once for each accepted read, and never before that read is accepted. `req_addr` is held while `req_valid` waits. The bench changes the configuration only after all queued requests have drained. It returns exactly one delayed data beat per accepted read, with a latency of zero to two cycles. It drives a request only when the block is idle, and holds that request until it is taken. Stalls on `mem_req_ready` and `rsp_ready` come from fixed cycle patterns, so the hold rules are exercised.

// File: rtl/tiled_xlate_pkg.sv
package tiled_xlate_pkg;
  localparam int VA_BITS      = 48;
  localparam int SEG_BITS     = 4;
  localparam int TILE_BITS    = 16;
  localparam int ROOT_IDX     = 9;
  localparam int MID_IDX      = 9;
  localparam int LEAF_IDX     = 10;
  localparam int PAGE_BITS    = 12;
  localparam int ENTRY_BITS   = 64;
  localparam int UPPER_SHIFT  = 3;
  localparam int LEAF_SHIFT   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/tiled_xlate_segsel.sv
module tiled_xlate_segsel #(
  parameter int SEG_W = 4
) (
  input  logic             en,
  input  logic [SEG_W-1:0] top_bits,
  input  logic [SEG_W-1:0] mask,
  input  logic [SEG_W-1:0] data,
  output logic             hit
);
  // masked nibble compare; disabled block never hits
  always_comb begin
    hit = en && (((top_bits ^ data) & mask) == '0);
  end
endmodule

// File: rtl/tiled_xlate_idxaddr.sv
module tiled_xlate_idxaddr #(
  parameter int VA_W     = 48,
  parameter int L3_W     = 9,
  parameter int L2_W     = 9,
  parameter int L1_W     = 10,
  parameter int UP_SH    = 3,
  parameter int LF_SH    = 2,
  parameter int LVL_W    = 2,
  localparam int IDX_W   = L3_W + L2_W + L1_W,
  localparam int NLVL    = 3
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic [IDX_W-1:0] idx_bits,
  input  logic [VA_W-1:0]  base,
  output logic [VA_W-1:0]  addr
);
  logic [VA_W-1:0] off [NLVL];

  // level 0 = root, 1 = mid, 2 = leaf
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int W  = (g == 0) ? L3_W : ((g == 1) ? L2_W : L1_W);
    localparam int LO = (g == 0) ? (L1_W + L2_W) : ((g == 1) ? L1_W : 0);
    localparam int SH = (g == NLVL - 1) ? LF_SH : UP_SH;
    assign off[g] = {{(VA_W - W){1'b0}}, idx_bits[LO +: W]} << SH;
  end

  always_comb begin
    addr = base;
    for (int i = 0; i < NLVL; i++) begin
      if (lvl == LVL_W'(i)) addr = base + off[i];
    end
  end
endmodule

// File: rtl/tiled_xlate_walk.sv
module tiled_xlate_walk
  import tiled_xlate_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int SEG_W   = 4,
  parameter int TILE_W  = 16,
  parameter int PAGE_W  = 12,
  parameter int ENT_W   = 64,
  parameter int LVL_W   = 2,
  localparam int LEAF_W = VA_W - TILE_W,
  localparam int IN_W   = VA_W - SEG_W,
  localparam int NLVL   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_hit,
  input  logic [LEAF_W-1:0] root_tile,
  input  logic [LEAF_W-1:0] null_pat,
  input  logic [LEAF_W-1:0] inv_pat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_addr,
  output logic              rsp_null,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [IN_W-1:0]   va_o,
  output logic [VA_W-1:0]   base_o
);
  walk_st_e          st_q, st_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [IN_W-1:0]   va_q;
  logic [VA_W-1:0]   base_q, base_d;
  logic [VA_W-1:0]   res_addr_q, res_addr_d;
  logic              res_null_q, res_null_d;
  logic              res_fault_q, res_fault_d;

  logic              ld_va, ld_base, ld_res, ld_lvl;
  logic              last_lvl, inv_hit, null_hit;
  logic [LEAF_W-1:0] leaf;

  assign leaf     = mem_rsp_data[LEAF_W-1:0];
  assign last_lvl = (lvl_q == LVL_W'(NLVL - 1));
  assign inv_hit  = last_lvl ? (leaf == inv_pat)
                             : (mem_rsp_data == ENT_W'(inv_pat));
  assign null_hit = last_lvl && (leaf == null_pat);

  // next-state logic
  always_comb begin
    st_d        = st_q;
    lvl_d       = lvl_q;
    base_d      = base_q;
    res_addr_d  = res_addr_q;
    res_null_d  = res_null_q;
    res_fault_d = res_fault_q;
    ld_va       = 1'b0;
    ld_base     = 1'b0;
    ld_res      = 1'b0;
    ld_lvl      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_va = 1'b1;
          if (seg_hit) begin
            st_d    = ST_ISSUE;
            ld_lvl  = 1'b1;
            lvl_d   = '0;
            ld_base = 1'b1;
            base_d  = {root_tile, TILE_W'(0)};
          end else begin
            st_d        = ST_RESP;
            ld_res      = 1'b1;
            res_addr_d  = req_addr;
            res_null_d  = 1'b0;
            res_fault_d = 1'b0;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (inv_hit) begin
            st_d        = ST_RESP;
            ld_res      = 1'b1;
            res_addr_d  = '0;
            res_null_d  = 1'b0;
            res_fault_d = 1'b1;
          end else if (!last_lvl) begin
            st_d    = ST_ISSUE;
            ld_lvl  = 1'b1;
            lvl_d   = lvl_q + 1'b1;
            ld_base = 1'b1;
            base_d  = {mem_rsp_data[VA_W-1:PAGE_W], PAGE_W'(0)};
          end else begin
            st_d        = ST_RESP;
            ld_res      = 1'b1;
            res_null_d  = null_hit;
            res_fault_d = 1'b0;
            res_addr_d  = null_hit ? '0 : {leaf, va_q[TILE_W-1:0]};
          end
        end
      end
      ST_RESP: begin
        if (rsp_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lvl_q       <= '0;
      va_q        <= '0;
      base_q      <= '0;
      res_addr_q  <= '0;
      res_null_q  <= 1'b0;
      res_fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_lvl)  lvl_q  <= lvl_d;
      if (ld_va)   va_q   <= req_addr[IN_W-1:0];
      if (ld_base) base_q <= base_d;
      if (ld_res) begin
        res_addr_q  <= res_addr_d;
        res_null_q  <= res_null_d;
        res_fault_q <= res_fault_d;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_addr      = res_addr_q;
  assign rsp_null      = res_null_q;
  assign rsp_fault     = res_fault_q;
  assign lvl_o         = lvl_q;
  assign va_o          = va_q;
  assign base_o        = base_q;
endmodule

// File: rtl/tiled_xlate.sv
module tiled_xlate #(
  parameter int VA_W   = tiled_xlate_pkg::VA_BITS,
  parameter int SEG_W  = tiled_xlate_pkg::SEG_BITS,
  parameter int TILE_W = tiled_xlate_pkg::TILE_BITS,
  parameter int L3_W   = tiled_xlate_pkg::ROOT_IDX,
  parameter int L2_W   = tiled_xlate_pkg::MID_IDX,
  parameter int L1_W   = tiled_xlate_pkg::LEAF_IDX,
  parameter int PAGE_W = tiled_xlate_pkg::PAGE_BITS,
  parameter int ENT_W  = tiled_xlate_pkg::ENTRY_BITS,
  parameter int UP_SH  = tiled_xlate_pkg::UPPER_SHIFT,
  parameter int LF_SH  = tiled_xlate_pkg::LEAF_SHIFT,
  localparam int LEAF_W = VA_W - TILE_W,
  localparam int IN_W   = VA_W - SEG_W,
  localparam int IDX_W  = L3_W + L2_W + L1_W,
  localparam int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [SEG_W-1:0]  cfg_seg_mask,
  input  logic [SEG_W-1:0]  cfg_seg_data,
  input  logic [LEAF_W-1:0] cfg_root_tile,
  input  logic [LEAF_W-1:0] cfg_null_pat,
  input  logic [LEAF_W-1:0] cfg_inv_pat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_addr,
  output logic              rsp_null,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data
);
  logic             seg_hit;
  logic [LVL_W-1:0] lvl;
  logic [IN_W-1:0]  va_held;
  logic [VA_W-1:0]  base;

  tiled_xlate_segsel #(.SEG_W(SEG_W)) u_segsel (
    .en       (cfg_enable),
    .top_bits (req_addr[VA_W-1 -: SEG_W]),
    .mask     (cfg_seg_mask),
    .data     (cfg_seg_data),
    .hit      (seg_hit)
  );

  tiled_xlate_walk #(
    .VA_W(VA_W), .SEG_W(SEG_W), .TILE_W(TILE_W), .PAGE_W(PAGE_W),
    .ENT_W(ENT_W), .LVL_W(LVL_W)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .seg_hit       (seg_hit),
    .root_tile     (cfg_root_tile),
    .null_pat      (cfg_null_pat),
    .inv_pat       (cfg_inv_pat),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_null      (rsp_null),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lvl_o         (lvl),
    .va_o          (va_held),
    .base_o        (base)
  );

  tiled_xlate_idxaddr #(
    .VA_W(VA_W), .L3_W(L3_W), .L2_W(L2_W), .L1_W(L1_W),
    .UP_SH(UP_SH), .LF_SH(LF_SH), .LVL_W(LVL_W)
  ) u_idxaddr (
    .lvl      (lvl),
    .idx_bits (va_held[TILE_W +: IDX_W]),
    .base     (base),
    .addr     (mem_req_addr)
  );
endmodule

// File: rtl/tiled_xlate_chk.sv
module tiled_xlate_chk #(
  parameter int VA_W  = 48,
  parameter int SEG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [SEG_W-1:0] cfg_seg_mask,
  input logic [SEG_W-1:0] cfg_seg_data,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VA_W-1:0]  rsp_addr,
  input logic             rsp_null,
  input logic             rsp_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [VA_W-1:0]  mem_req_addr
);
  logic accept, seg_miss;
  assign accept   = req_valid && req_ready;
  assign seg_miss = (((req_addr[VA_W-1 -: SEG_W] ^ cfg_seg_data) & cfg_seg_mask) != '0);

  // R2
  bypass_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cfg_enable |=> rsp_valid && (rsp_addr == $past(req_addr)) && !rsp_null && !rsp_fault);

  // R3
  seg_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_enable && seg_miss |=> rsp_valid && (rsp_addr == $past(req_addr)) && !rsp_fault);

  // R3
  seg_hit_walks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_enable && !seg_miss |=> mem_req_valid && !rsp_valid);

  // R4
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00) && !req_ready);

  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_null && rsp_fault));

  // R7
  flag_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_null || rsp_fault) |-> (rsp_addr == '0));

  // R8
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_null) && $stable(rsp_fault));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind tiled_xlate tiled_xlate_chk #(.VA_W(VA_W), .SEG_W(SEG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_seg_mask  (cfg_seg_mask),
  .cfg_seg_data  (cfg_seg_data),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_addr      (rsp_addr),
  .rsp_null      (rsp_null),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/tiled_xlate_tb_top.sv
module tiled_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] ROOT = 48'h0000_0040_0000;
  localparam logic [31:0] NULLP = 32'h0000_F00D;
  localparam logic [31:0] INVP  = 32'hDEAD_0001;

  logic        clk, rst_n;
  logic        cfg_enable;
  logic [3:0]  cfg_seg_mask, cfg_seg_data;
  logic [31:0] cfg_root_tile, cfg_null_pat, cfg_inv_pat;
  logic        req_valid, req_ready;
  logic [47:0] req_addr;
  logic        rsp_valid, rsp_ready, rsp_null, rsp_fault;
  logic [47:0] rsp_addr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [47:0] mem_req_addr;
  logic [63:0] mem_rsp_data;

  tiled_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_seg_mask(cfg_seg_mask), .cfg_seg_data(cfg_seg_data),
    .cfg_root_tile(cfg_root_tile), .cfg_null_pat(cfg_null_pat), .cfg_inv_pat(cfg_inv_pat),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_null(rsp_null), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] mem [logic [47:0]];
  logic [47:0] req_q [$];
  logic [47:0] exp_fetch_q [$];
  logic [47:0] exp_addr;
  logic        exp_null, exp_fault, exp_byp;
  string       byp_tag;
  bit          busy, byp_chk, req_taken, pend_v, stall_v;
  int          pend_cnt;
  logic [63:0] pend_d;
  logic [47:0] stall_a;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // behavioural walk over the bench memory, from the requirements
  task automatic ref_walk(input logic [47:0] va);
    logic [47:0] base, fa;
    logic [63:0] e;
    logic [31:0] idx;
    bit hit;
    hit = cfg_enable && (((va[47:44] ^ cfg_seg_data) & cfg_seg_mask) == 4'h0);
    exp_null = 0; exp_fault = 0; exp_byp = !hit;
    byp_tag = cfg_enable ? "R3" : "R2";
    if (!hit) begin
      exp_addr = va;
      return;
    end
    base = {cfg_root_tile, 16'h0};
    for (int lv = 0; lv < 3; lv++) begin
      idx = (lv == 0) ? 32'(va[43:35]) : (lv == 1) ? 32'(va[34:26]) : 32'(va[25:16]);
      fa = base + ((lv < 2) ? 48'(idx) * 48'd8 : 48'(idx) * 48'd4);
      exp_fetch_q.push_back(fa);
      e = rd(fa);
      if (lv < 2) begin
        if (e == {32'h0, cfg_inv_pat}) begin exp_fault = 1; exp_addr = '0; return; end
        base = {e[47:12], 12'h0};
      end else begin
        if (e[31:0] == cfg_inv_pat) begin exp_fault = 1; exp_addr = '0; end
        else if (e[31:0] == cfg_null_pat) begin exp_null = 1; exp_addr = '0; end
        else exp_addr = {e[31:0], va[15:0]};
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      req_valid = 0; req_addr = '0; rsp_ready = 0; mem_req_ready = 0;
      mem_rsp_valid = 0; mem_rsp_data = '0;
      busy = 0; byp_chk = 0; req_taken = 0; pend_v = 0; stall_v = 0;
    end else begin
      cyc++;
      // A: observe state reached at the last rising edge
      chk(req_ready == !busy, "R8 req_ready", 64'(req_ready), 64'(!busy));
      if (byp_chk) begin
        chk(rsp_valid == 1'b1, {byp_tag, " bypass latency"}, 64'(rsp_valid), 64'd1);
        byp_chk = 0;
      end
      if (stall_v) begin
        chk(mem_req_valid && (mem_req_addr == stall_a), "R9 read held", mem_req_addr, stall_a);
        stall_v = 0;
      end
      if (mem_req_valid && exp_fetch_q.size() == 0)
        chk(0, "R4 unexpected read", mem_req_addr, 64'h0);
      // C: drive inputs for the next rising edge
      rsp_ready = (cyc % 4) != 2;
      mem_req_ready = (cyc % 3) != 1;
      mem_rsp_valid = 0;
      if (pend_v) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = pend_d; pend_v = 0;
        end else pend_cnt--;
      end
      if (req_taken) begin req_valid = 0; req_taken = 0; end
      else if (!req_valid && !busy && req_q.size() > 0) begin
        req_valid = 1; req_addr = req_q.pop_front();
      end
      // B: handshakes that complete at the coming rising edge
      if (req_valid && req_ready) begin
        ref_walk(req_addr);
        busy = 1; req_taken = 1;
        if (exp_byp) byp_chk = 1;
      end
      if (mem_req_valid) begin
        if (mem_req_ready) begin
          if (exp_fetch_q.size() > 0) begin
            chk(mem_req_addr == exp_fetch_q[0], "R4 read address", mem_req_addr, exp_fetch_q[0]);
            void'(exp_fetch_q.pop_front());
          end
          pend_v = 1; pend_cnt = cyc % 3; pend_d = rd(mem_req_addr);
        end else begin
          stall_v = 1; stall_a = mem_req_addr;
        end
      end
      if (rsp_valid && rsp_ready) begin
        chk(busy, "R8 response while idle", 64'(busy), 64'd1);
        chk(exp_fetch_q.size() == 0, "R4 reads missing", 64'(exp_fetch_q.size()), 64'd0);
        chk(rsp_fault == exp_fault, "R6 fault flag", 64'(rsp_fault), 64'(exp_fault));
        chk(rsp_null == exp_null, "R7 null flag", 64'(rsp_null), 64'(exp_null));
        chk(rsp_addr == exp_addr, exp_byp ? byp_tag : "R5 address", rsp_addr, exp_addr);
        exp_fetch_q.delete();
        busy = 0;
      end
    end
  end

  function automatic logic [47:0] va_of(input logic [3:0] top, input int i3, input int i2,
                                        input int i1, input logic [15:0] off);
    return {top, 9'(i3), 9'(i2), 10'(i1), off};
  endfunction

  // upper entries carry junk outside 47:12, leaf words carry junk in 63:32 (R9)
  task automatic map_va(input logic [47:0] va, input logic [47:0] l2pg,
                        input logic [47:0] l1pg, input logic [31:0] tile);
    mem[ROOT + 48'(va[43:35]) * 8] = {16'hF00D, l2pg[47:12], 12'h5A5};
    mem[l2pg + 48'(va[34:26]) * 8] = {16'h0BAD, l1pg[47:12], 12'h003};
    mem[l1pg + 48'(va[25:16]) * 4] = {32'h7777_0000, tile};
  endtask

  task automatic drain();
    do begin @(negedge clk); #1; end
    while (req_q.size() > 0 || req_valid || busy);
    repeat (2) @(negedge clk);
    #2;
  endtask

  logic [47:0] va1, va2, va3, va4, va5, va6, va7;

  initial begin
    rst_n = 0;
    cfg_enable = 1; cfg_seg_mask = 4'hF; cfg_seg_data = 4'hF;
    cfg_root_tile = ROOT[47:16]; cfg_null_pat = NULLP; cfg_inv_pat = INVP;
    va1 = va_of(4'hF, 5, 7, 9, 16'h1234);
    va2 = va_of(4'hF, 511, 511, 1023, 16'hFFFF);
    va3 = va_of(4'hF, 0, 0, 0, 16'h0000);
    va4 = va_of(4'hF, 6, 3, 100, 16'h0042);
    va5 = va_of(4'hF, 8, 1, 2, 16'h0010);
    va6 = va_of(4'hF, 9, 4, 4, 16'h0020);
    va7 = va_of(4'hF, 10, 12, 77, 16'h0030);
    map_va(va1, 48'h0000_0080_0000, 48'h0000_0090_1000, 32'h0001_2345);
    map_va(va2, 48'h0000_00A0_0000, 48'h0000_00B0_0000, 32'hCAFE_0001);
    map_va(va3, 48'h0000_00C0_0000, 48'h0000_00D0_0000, 32'h0000_0777);
    map_va(va4, 48'h0000_00E0_0000, 48'h0000_00F0_0000, NULLP);
    map_va(va5, 48'h0000_0100_0000, 48'h0000_0110_0000, INVP);
    mem[ROOT + 48'(9) * 8] = {32'h0, INVP};
    mem[ROOT + 48'(10) * 8] = {16'h0, 36'h0000_0120_0, 12'h000};
    mem[48'h0000_0120_0000 + 48'(12) * 8] = {32'h0, INVP};

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    @(negedge clk); #2;
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1 after release", 64'(req_ready), 64'd1);

    // R5 mapped walks back to back, R7 null, R6 faults at every level
    req_q.push_back(va1); req_q.push_back(va2); req_q.push_back(va3);
    req_q.push_back(va4); req_q.push_back(va5); req_q.push_back(va6);
    req_q.push_back(va7);
    drain();

    // R3 out-of-slice address passes through
    req_q.push_back(va_of(4'h3, 5, 7, 9, 16'hABCD));
    drain();

    // R2 disabled: slice address passes through
    cfg_enable = 0;
    req_q.push_back(va1); req_q.push_back(va2);
    drain();

    // R3 partial mask: top nibble 5 hits, 9 misses
    cfg_enable = 1; cfg_seg_mask = 4'hC; cfg_seg_data = 4'h4;
    req_q.push_back(va_of(4'h5, 5, 7, 9, 16'h1234));
    req_q.push_back(va_of(4'h9, 5, 7, 9, 16'h1234));
    drain();

    // R3 empty mask: every address hits
    cfg_seg_mask = 4'h0;
    req_q.push_back(va_of(4'h0, 511, 511, 1023, 16'h0001));
    drain();

    // R6 priority: invalid pattern equal to null pattern gives a fault
    cfg_seg_mask = 4'hF; cfg_seg_data = 4'hF;
    cfg_inv_pat = NULLP;
    req_q.push_back(va4);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule